// File: doc/BRIEF.md
# Serial Register-File Slave with Deferred Readback

This block is the command port of a four-channel device. A host drives a four-wire serial link (serial clock, an active-low frame select, serial data in, serial data out) and sends command frames of 24 bits, MSB first. A write frame stores 16 bits into one register of the bank. Each channel has six 16-bit registers: data, control, gain, offset, clear code and slew setup. Three more registers serve the whole device: status, main control and supply control. All link inputs are synchronised into the system clock domain, and all edges are detected there.

A read frame returns nothing while it is being sent. It captures the addressed value, and that value comes out on the serial data output during the frame that follows. The host normally fills that following frame with a no-operation command (0x3CE000) or with its next read. A two-bit device address in every frame is compared against two strap inputs, so several slaves can share one link. When bit 0 of main control is set, the block is in check mode. Every frame then carries an 8-bit CRC after its 24 command bits, and readback frames grow to 32 bits.

Top module: `spirb_slave`

## Requirements
- R1: After reset every register reads zero, no readback is pending, check mode is off and the data-out enable is low.
- R2: While frame select is low, serial data in is sampled on each falling serial-clock edge. Bit 23 selects read (1) or write (0), bits 22:21 carry the device address, bits 20:16 the register select and bits 15:0 the write data. An accepted write stores the data into the selected register.
- R3: An accepted read enables data out for the whole of the next frame. Data out changes only after rising serial-clock edges and sends, MSB first, 8 zero bits followed by the 16-bit value the register held when the read frame ended.
- R4: Select s below 24 addresses channel s mod 4, register kind s/4, with kinds in the order data, control, gain, offset, clear code, slew. Select 24 is status (writes ignored), 25 is main control and 26 is supply control. Selects 27 to 31 ignore writes and read as zero.
- R5: A frame whose device-address field differs from the strap inputs changes no register and queues no readback. The next frame then leaves data out disabled.
- R6: A frame is discarded unless exactly 24 bits (32 in check mode) arrive before frame select rises.
- R7: Slew registers keep only bits 12 and 6:0 of written data. The other bits read as zero.
- R8: Main control bit 0 turns check mode on or off from the next frame onward. In check mode an incoming frame is 32 bits: 24 command bits followed by CRC-8 (polynomial 0x07, start value 0, MSB first) of those 24 bits.
- R9: In check mode, a 32-bit frame with a wrong CRC is discarded and sets status bit 0. An accepted read of status returns the flag and then clears it.
- R10: In check mode the readback frame is 32 bits: the 24 readback bits of R3 followed by their CRC-8.
- R11: A queued readback is dropped at the end of the next frame, whatever that frame is. A read accepted in that frame queues its own value for the frame after. Command 0xA80000 with strap value 1 reads channel A gain.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock, much faster than the serial clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| sclk_i | input | 1 | Serial clock, idles low |
| sync_ni | input | 1 | Active-low frame select |
| sdin_i | input | 1 | Serial command data |
| dev_addr_i | input | 2 | Device address straps |
| sdo_o | output | 1 | Serial readback data |
| sdo_oe_o | output | 1 | Output enable for the data-out pad (low means high impedance) |

## Verification
The assertions assume that serial-clock edges and frame-select edges are far apart in system clocks. In particular, an edge of frame select never arrives in the same synchronised cycle as a serial-clock edge, and no bit is shorter than the synchroniser delay. The stimulus holds each serial-clock phase for six system clocks and waits a full phase between frame select and the first or last clock edge. Random frames vary the command, the register select, the device address, the bit count and the CRC. Through main-control writes, the random frames also switch check mode on and off.

// File: rtl/spirb_pkg.sv
package spirb_pkg;

   localparam int CMD_W    = 24;
   localparam int CRC_W    = 8;
   localparam int PEC_W    = CMD_W + CRC_W;
   localparam int DATA_W   = 16;
   localparam int SEL_W    = 5;
   localparam int DEV_W    = 2;
   localparam int NUM_KIND = 6;
   localparam int SLEW_KIND = 5;

   localparam logic [CRC_W-1:0]  CRC_POLY  = 8'h07;
   localparam logic [DATA_W-1:0] SLEW_MASK = 16'h107F;

   typedef struct packed {
      logic              rd;
      logic [DEV_W-1:0]  dev;
      logic [SEL_W-1:0]  sel;
      logic [DATA_W-1:0] data;
   } cmd_t;

   function automatic logic [CRC_W-1:0] crc8_24(input logic [CMD_W-1:0] d);
      logic [CRC_W-1:0] c;
      c = '0;
      for (int i = CMD_W - 1; i >= 0; i--) begin
         if (c[CRC_W-1] ^ d[i]) c = {c[CRC_W-2:0], 1'b0} ^ CRC_POLY;
         else                   c = {c[CRC_W-2:0], 1'b0};
      end
      return c;
   endfunction

endpackage

// File: rtl/spirb_sync_edge.sv
module spirb_sync_edge #(
   parameter int STAGES = 2
) (
   input  logic clk_i,
   input  logic rst_ni,
   input  logic sclk_i,
   input  logic sync_ni,
   input  logic sdin_i,
   output logic frame_act_o,
   output logic frame_start_o,
   output logic frame_end_o,
   output logic sclk_rise_o,
   output logic sclk_fall_o,
   output logic sdin_o
);

   // bit 0 serial clock, bit 1 frame select, bit 2 data
   localparam logic [2:0] IDLE = 3'b010;

   if (STAGES < 2) begin : g_bad_stages
      $error("spirb_sync_edge: STAGES must be at least 2");
   end

   logic [2:0] stage_q [STAGES];
   logic [2:0] last_q;
   logic [2:0] cur;

   for (genvar g = 0; g < STAGES; g++) begin : g_stage
      if (g == 0) begin : g_first
         always_ff @(posedge clk_i or negedge rst_ni) begin
            if (!rst_ni) stage_q[g] <= IDLE;
            else         stage_q[g] <= {sdin_i, sync_ni, sclk_i};
         end
      end else begin : g_next
         always_ff @(posedge clk_i or negedge rst_ni) begin
            if (!rst_ni) stage_q[g] <= IDLE;
            else         stage_q[g] <= stage_q[g-1];
         end
      end
   end

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) last_q <= IDLE;
      else         last_q <= stage_q[STAGES-1];
   end

   assign cur           = stage_q[STAGES-1];
   assign frame_act_o   = !cur[1];
   assign frame_start_o = !cur[1] &&  last_q[1];
   assign frame_end_o   =  cur[1] && !last_q[1];
   assign sclk_rise_o   =  cur[0] && !last_q[0];
   assign sclk_fall_o   = !cur[0] &&  last_q[0];
   assign sdin_o        =  cur[2];

endmodule

// File: rtl/spirb_frame_rx.sv
module spirb_frame_rx
   import spirb_pkg::*;
#(
   parameter bit PEC_SUPPORT = 1'b1,
   parameter int CNT_W       = 6
) (
   input  logic clk_i,
   input  logic rst_ni,
   input  logic frame_start_i,
   input  logic frame_act_i,
   input  logic sclk_fall_i,
   input  logic sdin_i,
   input  logic pec_mode_i,
   output cmd_t cmd_o,
   output logic ok_o,
   output logic crc_bad_o
);

   localparam int CNT_MAX = (1 << CNT_W) - 1;

   if (CNT_MAX <= PEC_W) begin : g_bad_cnt
      $error("spirb_frame_rx: CNT_W too small for a checked frame");
   end

   logic [PEC_W-1:0] shreg_q;
   logic [CNT_W-1:0] bcnt_q;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         shreg_q <= '0;
         bcnt_q  <= '0;
      end else if (frame_start_i) begin
         shreg_q <= '0;
         bcnt_q  <= '0;
      end else if (frame_act_i && sclk_fall_i) begin
         shreg_q <= {shreg_q[PEC_W-2:0], sdin_i};
         if (bcnt_q != CNT_W'(CNT_MAX)) bcnt_q <= bcnt_q + 1'b1;
      end
   end

   if (PEC_SUPPORT) begin : g_pec
      logic crc_match;
      assign crc_match = (crc8_24(shreg_q[PEC_W-1:CRC_W]) == shreg_q[CRC_W-1:0]);
      always_comb begin
         if (pec_mode_i) begin
            cmd_o     = cmd_t'(shreg_q[PEC_W-1:CRC_W]);
            ok_o      = (bcnt_q == CNT_W'(PEC_W)) && crc_match;
            crc_bad_o = (bcnt_q == CNT_W'(PEC_W)) && !crc_match;
         end else begin
            cmd_o     = cmd_t'(shreg_q[CMD_W-1:0]);
            ok_o      = (bcnt_q == CNT_W'(CMD_W));
            crc_bad_o = 1'b0;
         end
      end
   end else begin : g_plain
      logic unused_hi;
      assign unused_hi = ^{pec_mode_i, shreg_q[PEC_W-1:CMD_W]};
      assign cmd_o     = cmd_t'(shreg_q[CMD_W-1:0]);
      assign ok_o      = (bcnt_q == CNT_W'(CMD_W));
      assign crc_bad_o = 1'b0;
   end

endmodule

// File: rtl/spirb_regbank.sv
module spirb_regbank
   import spirb_pkg::*;
#(
   parameter int NUM_CH      = 4,
   parameter bit PEC_SUPPORT = 1'b1
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic              we_i,
   input  logic [SEL_W-1:0]  wsel_i,
   input  logic [DATA_W-1:0] wdata_i,
   input  logic [SEL_W-1:0]  rsel_i,
   input  logic [DATA_W-1:0] status_i,
   output logic [DATA_W-1:0] rdata_o,
   output logic              pec_en_o
);

   localparam int NUM_LOCAL = NUM_KIND * NUM_CH;
   localparam int SEL_STAT  = NUM_LOCAL;
   localparam int SEL_MAIN  = NUM_LOCAL + 1;
   localparam int SEL_SUPP  = NUM_LOCAL + 2;

   if (SEL_SUPP >= (1 << SEL_W)) begin : g_bad_map
      $error("spirb_regbank: register map exceeds select range");
   end

   logic [DATA_W-1:0] loc_q [NUM_LOCAL];
   logic [DATA_W-1:0] main_q;
   logic [DATA_W-1:0] supp_q;

   for (genvar r = 0; r < NUM_LOCAL; r++) begin : g_reg
      localparam logic [DATA_W-1:0] KEEP =
         ((r / NUM_CH) == SLEW_KIND) ? SLEW_MASK : {DATA_W{1'b1}};
      always_ff @(posedge clk_i or negedge rst_ni) begin
         if (!rst_ni)                                  loc_q[r] <= '0;
         else if (we_i && (wsel_i == SEL_W'(r)))       loc_q[r] <= wdata_i & KEEP;
      end
   end

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         main_q <= '0;
         supp_q <= '0;
      end else if (we_i) begin
         if (wsel_i == SEL_W'(SEL_MAIN)) main_q <= wdata_i;
         if (wsel_i == SEL_W'(SEL_SUPP)) supp_q <= wdata_i;
      end
   end

   always_comb begin
      rdata_o = '0;
      for (int r = 0; r < NUM_LOCAL; r++) begin
         if (rsel_i == SEL_W'(r)) rdata_o = loc_q[r];
      end
      if (rsel_i == SEL_W'(SEL_STAT)) rdata_o = status_i;
      if (rsel_i == SEL_W'(SEL_MAIN)) rdata_o = main_q;
      if (rsel_i == SEL_W'(SEL_SUPP)) rdata_o = supp_q;
   end

   if (PEC_SUPPORT) begin : g_pec_on
      assign pec_en_o = main_q[0];
   end else begin : g_pec_off
      assign pec_en_o = 1'b0;
   end

endmodule

// File: rtl/spirb_tx.sv
module spirb_tx #(
   parameter int W = 32
) (
   input  logic         clk_i,
   input  logic         rst_ni,
   input  logic         frame_start_i,
   input  logic         frame_act_i,
   input  logic         sclk_rise_i,
   input  logic         pend_i,
   input  logic [W-1:0] word_i,
   output logic         sdo_o,
   output logic         oe_o
);

   logic [W-1:0] sr_q;
   logic         sdo_q;
   logic         oe_q;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         sr_q  <= '0;
         sdo_q <= 1'b0;
         oe_q  <= 1'b0;
      end else begin
         oe_q <= frame_act_i && pend_i;
         if (frame_start_i && pend_i) begin
            sr_q <= word_i;
         end else if (frame_act_i && sclk_rise_i) begin
            sdo_q <= sr_q[W-1];
            sr_q  <= {sr_q[W-2:0], 1'b0};
         end
      end
   end

   assign sdo_o = sdo_q;
   assign oe_o  = oe_q;

endmodule

// File: rtl/spirb_slave.sv
module spirb_slave
   import spirb_pkg::*;
#(
   parameter int NUM_CH      = 4,
   parameter int SYNC_STAGES = 2,
   parameter bit PEC_SUPPORT = 1'b1,
   parameter int CNT_W       = 6
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic             sclk_i,
   input  logic             sync_ni,
   input  logic             sdin_i,
   input  logic [DEV_W-1:0] dev_addr_i,
   output logic             sdo_o,
   output logic             sdo_oe_o
);

   localparam int SEL_STAT = NUM_KIND * NUM_CH;

   if (NUM_CH != 1 && NUM_CH != 2 && NUM_CH != 4) begin : g_bad_ch
      $error("spirb_slave: NUM_CH must be 1, 2 or 4");
   end

   logic frame_act, frame_start, frame_end, sclk_rise, sclk_fall, sdin_s;
   cmd_t cmd;
   logic frame_ok, crc_bad, pec_en, accept;
   logic rd_pend, crc_err;
   logic [DATA_W-1:0] rdata;
   logic [PEC_W-1:0]  rb_word;

   spirb_sync_edge #(.STAGES(SYNC_STAGES)) u_sync (
      .clk_i, .rst_ni, .sclk_i, .sync_ni, .sdin_i,
      .frame_act_o   (frame_act),
      .frame_start_o (frame_start),
      .frame_end_o   (frame_end),
      .sclk_rise_o   (sclk_rise),
      .sclk_fall_o   (sclk_fall),
      .sdin_o        (sdin_s)
   );

   spirb_frame_rx #(.PEC_SUPPORT(PEC_SUPPORT), .CNT_W(CNT_W)) u_rx (
      .clk_i, .rst_ni,
      .frame_start_i (frame_start),
      .frame_act_i   (frame_act),
      .sclk_fall_i   (sclk_fall),
      .sdin_i        (sdin_s),
      .pec_mode_i    (pec_en),
      .cmd_o         (cmd),
      .ok_o          (frame_ok),
      .crc_bad_o     (crc_bad)
   );

   assign accept = frame_end && frame_ok && (cmd.dev == dev_addr_i);

   spirb_regbank #(.NUM_CH(NUM_CH), .PEC_SUPPORT(PEC_SUPPORT)) u_bank (
      .clk_i, .rst_ni,
      .we_i     (accept && !cmd.rd),
      .wsel_i   (cmd.sel),
      .wdata_i  (cmd.data),
      .rsel_i   (cmd.sel),
      .status_i ({{(DATA_W-1){1'b0}}, crc_err}),
      .rdata_o  (rdata),
      .pec_en_o (pec_en)
   );

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         rd_pend <= 1'b0;
         crc_err <= 1'b0;
         rb_word <= '0;
      end else if (frame_end) begin
         rd_pend <= accept && cmd.rd;
         if (accept && cmd.rd) begin
            if (pec_en) rb_word <= {8'h00, rdata, crc8_24({8'h00, rdata})};
            else        rb_word <= {8'h00, rdata, 8'h00};
            if (cmd.sel == SEL_W'(SEL_STAT)) crc_err <= 1'b0;
         end
         if (crc_bad) crc_err <= 1'b1;
      end
   end

   spirb_tx #(.W(PEC_W)) u_tx (
      .clk_i, .rst_ni,
      .frame_start_i (frame_start),
      .frame_act_i   (frame_act),
      .sclk_rise_i   (sclk_rise),
      .pend_i        (rd_pend),
      .word_i        (rb_word),
      .sdo_o         (sdo_o),
      .oe_o          (sdo_oe_o)
   );

endmodule

// File: rtl/spirb_slave_chk.sv
module spirb_slave_chk (
   input logic clk,
   input logic rst_n,
   input logic frame_act,
   input logic frame_end,
   input logic sclk_rise,
   input logic sdo,
   input logic sdo_oe,
   input logic rd_pend,
   input logic pec_en,
   input logic crc_err
);

   // R3: the pad is only driven inside a frame
   p_oe_in_frame_r3: assert property (@(posedge clk) disable iff (!rst_n)
      sdo_oe |-> $past(frame_act));

   // R3: data out moves only after a rising serial-clock edge
   p_sdo_on_rise_r3: assert property (@(posedge clk) disable iff (!rst_n)
      !sclk_rise |=> $stable(sdo));

   // R11: a readback is queued only when a frame closes
   p_pend_at_end_r11: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rd_pend) |-> $past(frame_end));

   // R8: check mode changes only at a frame boundary
   p_mode_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
      !frame_end |=> $stable(pec_en));

   // R9: the CRC flag rises only at the end of a checked frame
   p_crc_flag_r9: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(crc_err) |-> $past(frame_end && pec_en));

endmodule

bind spirb_slave spirb_slave_chk chk_i (
   .clk       (clk_i),
   .rst_n     (rst_ni),
   .frame_act (frame_act),
   .frame_end (frame_end),
   .sclk_rise (sclk_rise),
   .sdo       (sdo_o),
   .sdo_oe    (sdo_oe_o),
   .rd_pend   (rd_pend),
   .pec_en    (pec_en),
   .crc_err   (crc_err)
);

// File: tb/spirb_slave_tb.sv
module spirb_slave_tb_top;

   localparam int CLK_PERIOD = 10;
   localparam int HALF       = 6;
   localparam logic [1:0] STRAP = 2'd1;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic sclk = 1'b0;
   logic sync_n = 1'b1;
   logic sdin = 1'b0;
   logic sdo, sdo_oe;

   int checks = 0;
   int errors = 0;

   // reference model state
   logic [15:0] m_reg [32];
   logic        m_pec, m_crc, m_pend;
   logic [31:0] m_exp;
   int          m_len;

   always #(CLK_PERIOD/2) clk = ~clk;

   spirb_slave dut_i (
      .clk_i(clk), .rst_ni(rst_n), .sclk_i(sclk), .sync_ni(sync_n),
      .sdin_i(sdin), .dev_addr_i(STRAP), .sdo_o(sdo), .sdo_oe_o(sdo_oe)
   );

   task automatic summary();
      $display("Result: errors=%0d of %0d checks", errors, checks);
   endtask

   initial begin
      repeat (190000) @(posedge clk);
      checks++;
      errors++;
      $display("FAIL watchdog: actual=hung expected=done");
      summary();
      $finish;
   end

   task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
      end
   endtask

   function automatic logic [7:0] ref_crc(input logic [23:0] d);
      logic [7:0] c = 8'h00;
      for (int i = 23; i >= 0; i--) begin
         logic top = c[7] ^ d[i];
         c = {c[6:0], 1'b0};
         if (top) c = c ^ 8'h07;
      end
      return c;
   endfunction

   function automatic logic [15:0] m_read(input int s);
      if (s < 24)  return m_reg[s];
      if (s == 24) return {15'd0, m_crc};
      if (s == 25 || s == 26) return m_reg[s];
      return 16'h0000;
   endfunction

   task automatic m_write(input int s, input logic [15:0] d);
      if (s < 20)                 m_reg[s] = d;
      else if (s < 24)            m_reg[s] = d & 16'h107F;
      else if (s == 25) begin     m_reg[s] = d; m_pec = d[0]; end
      else if (s == 26)           m_reg[s] = d;
   endtask

   task automatic m_reset();
      for (int i = 0; i < 32; i++) m_reg[i] = 16'h0;
      m_pec = 0; m_crc = 0; m_pend = 0; m_exp = 0; m_len = 24;
   endtask

   task automatic wait_clk(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic do_reset();
      sync_n = 1; sclk = 0; sdin = 0; rst_n = 0;
      wait_clk(4);
      rst_n = 1;
      m_reset();
      wait_clk(4);
   endtask

   // send nb bits of w, compare readback, then update model
   task automatic frame(input logic [31:0] w, input int nb, input string tag);
      logic [31:0] got = 0;
      int oe_hi = 0, oe_lo = 0, exp_len;
      logic [23:0] c;
      logic crc_ok;
      sync_n = 0;
      wait_clk(HALF);
      for (int i = nb - 1; i >= 0; i--) begin
         sdin = w[i]; sclk = 1;
         wait_clk(HALF);
         got = {got[30:0], sdo};
         if (sdo_oe) oe_hi++; else oe_lo++;
         sclk = 0;
         wait_clk(HALF);
      end
      sync_n = 1;
      wait_clk(2 * HALF);
      if (m_pend) begin
         chk(oe_lo == 0, tag, oe_lo, 0);
         if (nb == m_len) begin
            logic [31:0] mask = (m_len == 32) ? 32'hFFFF_FFFF : 32'h00FF_FFFF;
            chk((got & mask) == m_exp, tag, got & mask, m_exp);
         end
      end else begin
         chk(oe_hi == 0, tag, oe_hi, 0);
      end
      m_pend = 0;
      exp_len = m_pec ? 32 : 24;
      if (nb == exp_len) begin
         c = m_pec ? w[31:8] : w[23:0];
         crc_ok = !m_pec || (ref_crc(w[31:8]) == w[7:0]);
         if (!crc_ok) m_crc = 1;
         else if (c[22:21] == STRAP) begin
            if (c[23]) begin
               logic [15:0] v = m_read(int'(c[20:16]));
               m_len = exp_len;
               m_exp = m_pec ? {8'h00, v, ref_crc({8'h00, v})} : {8'h00, 8'h00, v};
               m_pend = 1;
               if (c[20:16] == 5'd24) m_crc = 0;
            end else begin
               m_write(int'(c[20:16]), c[15:0]);
            end
         end
      end
   endtask

   function automatic logic [23:0] mk(input bit rd, input logic [1:0] dv, input int s, input logic [15:0] d);
      return {rd, dv, 5'(s), d};
   endfunction

   task automatic send(input logic [23:0] c, input string tag);
      if (m_pec) frame({c, ref_crc(c)}, 32, tag);
      else       frame({8'h00, c}, 24, tag);
   endtask

   task automatic rd(input int s, input string tag);
      send(mk(1, STRAP, s, 16'h0), tag);
   endtask

   task automatic nop(input string tag);
      send(24'h3CE000, tag);
   endtask

   initial begin
      void'($urandom(32'd20240611));
      m_reset();
      do_reset();

      // R1: reset state
      chk(sdo_oe == 0, "R1 oe", 32'(sdo_oe), 0);
      nop("R1 idle");
      rd(24, "R1"); rd(25, "R1"); rd(5, "R1"); nop("R1");

      // R2 R3 R11: documented example, back-to-back reads
      send(mk(0, STRAP, 8, 16'h1234), "R2");
      send(mk(0, STRAP, 0, 16'hBEEF), "R2");
      send(24'hA80000, "R11");
      nop("R11 example");
      rd(0, "R3"); rd(8, "R11 chain"); nop("R11 chain");
      // R11: a write in the return frame, then a read queued from it
      rd(0, "R11"); send(mk(0, STRAP, 0, 16'h0F0F), "R11 wr"); nop("R11 none");
      rd(0, "R2"); nop("R2");

      // R7: slew masking
      send(mk(0, STRAP, 21, 16'hFFFF), "R7"); rd(21, "R7"); nop("R7");
      // R4: map edges
      send(mk(0, STRAP, 27, 16'hAAAA), "R4"); send(mk(0, STRAP, 31, 16'h5555), "R4");
      send(mk(0, STRAP, 24, 16'hFFFF), "R4"); send(mk(0, STRAP, 26, 16'hC3C3), "R4");
      rd(27, "R4"); rd(31, "R4"); rd(24, "R4"); rd(26, "R4"); rd(23, "R4"); nop("R4");
      // R5: address mismatch
      send(mk(0, 2'd2, 8, 16'h9999), "R5"); rd(8, "R5"); nop("R5");
      send(mk(1, 2'd3, 8, 16'h0), "R5"); nop("R5 oe");
      // R6: wrong bit counts
      frame({8'h00, mk(0, STRAP, 8, 16'h7777)} >> 1, 23, "R6");
      frame({mk(0, STRAP, 8, 16'h6666), 1'b0}, 25, "R6");
      rd(8, "R6"); nop("R6");

      // R8 R10: check mode
      send(mk(0, STRAP, 25, 16'h0001), "R8");
      rd(8, "R10"); rd(25, "R10"); nop("R10");
      frame({8'h00, mk(0, STRAP, 8, 16'h4444)}, 24, "R8 short");
      rd(8, "R8"); nop("R8");
      // R9: bad CRC
      frame({mk(0, STRAP, 8, 16'h2222), ~ref_crc(mk(0, STRAP, 8, 16'h2222))}, 32, "R9");
      rd(24, "R9"); rd(24, "R9 clr"); rd(8, "R9"); nop("R9");
      send(mk(0, STRAP, 25, 16'h0000), "R8 off");
      rd(25, "R8"); nop("R8");

      // random mix
      for (int n = 0; n < 130; n++) begin
         int r = $urandom % 100;
         int s = $urandom % 32;
         logic [15:0] d = 16'($urandom);
         logic [1:0] dv = ($urandom % 10 < 8) ? STRAP : 2'($urandom);
         if (r < 35) begin
            logic [23:0] c = mk(0, dv, s, d);
            if (m_pec && ($urandom % 10 == 0)) frame({c, ~ref_crc(c)}, 32, "R9 rnd");
            else send(c, "R2 rnd");
         end else if (r < 72) send(mk(1, dv, s, 16'h0), "R3 rnd");
         else if (r < 88) nop("R11 rnd");
         else begin
            int nb = 8 + ($urandom % 24);
            if (nb == (m_pec ? 32 : 24)) nb = nb - 1;
            frame({$urandom}, nb, "R6 rnd");
         end
      end
      nop("R3 rnd");

      // R1: reset clears written state
      send(mk(0, STRAP, 25, 16'h0001), "R1");
      send(mk(0, STRAP, 9, 16'h8888), "R1");
      do_reset();
      chk(sdo_oe == 0, "R1 oe", 32'(sdo_oe), 0);
      rd(9, "R1"); rd(25, "R1"); nop("R1");

      summary();
      $finish;
   end

endmodule